// File: doc/BRIEF.md
# Burst DMA Request Generator

This block is the peripheral side of DMA on an 8-bit card with an ISA-style bus. Host software starts a burst by writing to one control-register I/O address. The value written does not matter. The write raises the DMA request line and clears an internal count of transfers. The DMA controller then answers each request with its acknowledge. It moves one byte per transfer with a read or write strobe.

The block counts each acknowledged transfer when its strobe ends. It drops the request once a full burst of `BURST_LEN` transfers (16 by default) is done. It drops it earlier if the controller flags terminal count during a transfer. No other event ends a burst, so the host sees each burst as one unbroken operation. A control write that arrives during a burst is ignored.

A data-latch enable tells the storage device when a byte moves. A one-cycle done pulse marks the end of each burst. All inputs are taken as synchronous to `clk`.

Top module: `burst_dreq_gen`

## Requirements
- R1: A synchronous active-high reset drives `drq` and `burst_done` low. A reset that arrives during a burst ends it, and later strobes do not raise `drq` again.
- R2: A write to `CTRL_ADDR` asserts `drq` at the clock edge that samples the first high cycle of `cpu_wr`. The value of the write is not examined. A write held for several cycles counts as one write.
- R3: A `cpu_wr` with any address other than `CTRL_ADDR` leaves `drq` low.
- R4: A transfer is complete when `ior` or `iow` goes low after a cycle in which it was high together with `dack`. `drq` falls at the clock edge that samples the end of the `BURST_LEN`-th completed transfer, and not before.
- R5: If `tc` is high during a transfer, `drq` falls when that transfer completes, whatever the count.
- R6: A write to `CTRL_ADDR` during a burst is ignored. It neither restarts the count nor lengthens the burst.
- R7: A strobe while `dack` is low is not counted. A transfer while no burst is active has no effect.
- R8: `burst_done` is high for exactly one cycle, the first cycle in which `drq` is low after a burst ends by count or by `tc`.
- R9: Each accepted write starts from a count of zero, so every burst that `tc` does not cut short lasts exactly `BURST_LEN` transfers.
- R10: `latch_en` is high while `drq`, `dack` and either `ior` or `iow` are all high. It is low whenever no burst is active.
- R11: A strobe held high for several cycles counts as one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU I/O write strobe, active high |
| cpu_addr | input | ADDR_W | CPU I/O address |
| dack | input | 1 | DMA acknowledge, active high |
| ior | input | 1 | I/O read strobe during a DMA cycle, active high |
| iow | input | 1 | I/O write strobe during a DMA cycle, active high |
| tc | input | 1 | Terminal count from the DMA controller |
| drq | output | 1 | DMA request, driven from a register |
| latch_en | output | 1 | Data-latch enable toward the storage device |
| burst_done | output | 1 | One-cycle pulse when a burst ends |

## Verification
A table of bursts covers five cases: no terminal count, terminal count on the first transfer, terminal count mid-burst, terminal count just before the last transfer, and terminal count on the last one. A count that is off by one fails the uncut case, and a terminal-count flag that is latched too late or ignored fails the cut cases. Directed sequences mix an ignored second write and an unacknowledged strobe into one burst, which tells apart a block that restarts, or counts every strobe, from one that does neither. Further cases cover a held strobe, which catches level counting instead of edge counting, a write to the wrong address, and a reset in mid-burst, which shows that the counter clears.

// File: rtl/bdg_pkg.sv
package bdg_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_BURST = 1'b1
    } phase_e;

    function automatic int unsigned cnt_width(input int unsigned len);
        return $clog2(len + 1);
    endfunction

endpackage

// File: rtl/bdg_reg_decode.sv
module bdg_reg_decode #(
    parameter int unsigned    ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              wr_hit
);

    logic wr_prev_d, wr_prev_q;

    always_comb begin
        wr_prev_d = cpu_wr;
        wr_hit    = cpu_wr && !wr_prev_q && (cpu_addr == CTRL_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) wr_prev_q <= 1'b0;
        else     wr_prev_q <= wr_prev_d;
    end

endmodule

// File: rtl/bdg_xfer_detect.sv
module bdg_xfer_detect (
    input  logic clk,
    input  logic rst,
    input  logic dack,
    input  logic ior,
    input  logic iow,
    input  logic tc,
    output logic strobe_act,
    output logic xfer_done,
    output logic xfer_tc
);

    typedef struct packed {
        logic in_xfer;
        logic tc_seen;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        strobe_act = dack && (ior || iow);
        det_d.in_xfer = strobe_act;
        if (strobe_act)
            det_d.tc_seen = (det_q.in_xfer && det_q.tc_seen) || tc;
        else
            det_d.tc_seen = 1'b0;
        xfer_done = det_q.in_xfer && !strobe_act;
        xfer_tc   = det_q.tc_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= '0;
        else     det_q <= det_d;
    end

endmodule

// File: rtl/bdg_burst_ctrl.sv
module bdg_burst_ctrl #(
    parameter int unsigned BURST_LEN = 16,
    localparam int unsigned CNT_W    = bdg_pkg::cnt_width(BURST_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic xfer_done,
    input  logic xfer_tc,
    output logic drq,
    output logic done
);
    import bdg_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        cnt_inc    = ctl_q.cnt + 1'b1;
        if (ctl_q.phase == PH_IDLE) begin
            if (wr_hit) begin
                ctl_d.phase = PH_BURST;
                ctl_d.cnt   = '0;
            end
        end else if (xfer_done) begin
            ctl_d.cnt = cnt_inc;
            if (cnt_inc == CNT_W'(BURST_LEN) || xfer_tc) begin
                ctl_d.phase = PH_IDLE;
                ctl_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drq  = (ctl_q.phase == PH_BURST);
    assign done = ctl_q.done;

endmodule

// File: rtl/burst_dreq_gen.sv
module burst_dreq_gen #(
    parameter int unsigned       ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h300,
    parameter int unsigned       BURST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dack,
    input  logic              ior,
    input  logic              iow,
    input  logic              tc,
    output logic              drq,
    output logic              latch_en,
    output logic              burst_done
);

    logic wr_hit;
    logic strobe_act;
    logic xfer_done;
    logic xfer_tc;

    bdg_reg_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) dec_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .wr_hit(wr_hit)
    );

    bdg_xfer_detect det_i (
        .clk(clk), .rst(rst), .dack(dack), .ior(ior), .iow(iow), .tc(tc),
        .strobe_act(strobe_act), .xfer_done(xfer_done), .xfer_tc(xfer_tc)
    );

    bdg_burst_ctrl #(.BURST_LEN(BURST_LEN)) ctl_i (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .xfer_done(xfer_done),
        .xfer_tc(xfer_tc), .drq(drq), .done(burst_done)
    );

    assign latch_en = drq && strobe_act;

endmodule

// File: rtl/bdg_checker.sv
module bdg_checker #(
    parameter int unsigned BURST_LEN = 16
) (
    input logic clk,
    input logic rst,
    input logic drq,
    input logic done,
    input logic latch_en,
    input logic wr_hit,
    input logic xfer_done
);

    logic [15:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)                  seen_q <= '0;
        else if (!drq)            seen_q <= '0;
        else if (xfer_done)       seen_q <= seen_q + 16'd1;
    end

    // R4: no more than BURST_LEN completions inside one burst
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        seen_q <= 16'(BURST_LEN));

    // R2: a rising request needs an accepted control write
    a_r2_rise_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(drq) |-> $past(wr_hit));

    // R8: pulse only on the first low cycle after a burst
    a_r8_done_after_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> (!drq && $past(drq)));

    // R8: every fall outside reset gives a pulse
    a_r8_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
        ($past(drq) && !drq && !$past(rst)) |-> done);

    // R10: no latch enable without an active burst
    a_r10_latch_idle: assert property (@(posedge clk) disable iff (rst)
        !drq |-> !latch_en);

endmodule

bind burst_dreq_gen bdg_checker #(.BURST_LEN(BURST_LEN)) chk_i (
    .clk(clk), .rst(rst), .drq(drq), .done(burst_done),
    .latch_en(latch_en), .wr_hit(wr_hit), .xfer_done(xfer_done)
);

// File: tb/burst_dreq_gen_tb_top.sv
module burst_dreq_gen_tb_top;

    localparam int unsigned ADDR_W = 10;
    localparam logic [ADDR_W-1:0] CTRL = 10'h300;
    localparam int unsigned LEN = 16;

    // each entry: {tc_at[4:0], expected_len[4:0]}; tc_at 0 means no terminal count
    localparam int NVEC = 5;
    localparam logic [9:0] VEC [NVEC] = '{
        {5'd0,  5'd16},
        {5'd1,  5'd1},
        {5'd7,  5'd7},
        {5'd15, 5'd15},
        {5'd16, 5'd16}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_wr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic dack = 1'b0, ior = 1'b0, iow = 1'b0, tc = 1'b0;
    logic drq, latch_en, burst_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_dreq_gen #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL), .BURST_LEN(LEN)) dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .dack(dack), .ior(ior), .iow(iow), .tc(tc),
        .drq(drq), .latch_en(latch_en), .burst_done(burst_done)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input int hold);
        cpu_addr = a;
        cpu_wr   = 1'b1;
        repeat (hold) @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic xfer(input bit rd, input bit tcv, input int hold, input bit chk_latch, input bit exp_latch);
        dack = 1'b1;
        ior  = rd;
        iow  = !rd;
        tc   = tcv;
        #1;
        if (chk_latch) chk("R10 latch_en during strobe", latch_en, exp_latch);
        repeat (hold) @(negedge clk);
        ior = 1'b0;
        iow = 1'b0;
        tc  = 1'b0;
        @(negedge clk);
        dack = 1'b0;
    endtask

    task automatic bare_strobe();
        ior = 1'b1;
        @(negedge clk);
        ior = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_xfers(input int n, input int base);
        for (int k = 0; k < n; k++) xfer(((base + k) % 2) == 0, 1'b0, 1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 drq after reset", drq, 1'b0);
        chk("R1 done after reset", burst_done, 1'b0);
        #1 chk("R10 latch idle", latch_en, 1'b0);

        // table of bursts (R4, R5, R8, R9)
        for (int v = 0; v < NVEC; v++) begin
            int tc_at;
            int elen;
            tc_at = int'(VEC[v][9:5]);
            elen  = int'(VEC[v][4:0]);
            host_write(CTRL, 1);
            chk("R2 drq after write", drq, 1'b1);
            chk("R9 no done at start", burst_done, 1'b0);
            for (int i = 1; i <= elen; i++) begin
                xfer((i % 2) == 1, i == tc_at, 1, i == 1, 1'b1);
                if (tc_at != 0) chk("R5 drq vs terminal count", drq, i < elen);
                else            chk("R4 drq vs transfer count", drq, i < elen);
                chk("R8 done pulse", burst_done, i == elen);
            end
            @(negedge clk);
            chk("R8 done lasts one cycle", burst_done, 1'b0);
            xfer(1'b1, 1'b0, 1, 1'b1, 1'b0);
            chk("R7 transfer while idle", drq, 1'b0);
            chk("R7 no done while idle", burst_done, 1'b0);
        end

        // wrong address (R3)
        host_write(CTRL ^ 10'h001, 1);
        chk("R3 other address", drq, 1'b0);
        @(negedge clk);
        chk("R3 other address later", drq, 1'b0);

        // write during burst and strobe without dack (R6, R7)
        host_write(CTRL, 1);
        run_xfers(4, 0);
        host_write(CTRL, 1);
        chk("R6 still active after write", drq, 1'b1);
        bare_strobe();
        chk("R7 strobe without dack", drq, 1'b1);
        run_xfers(11, 4);
        chk("R6 active after 15", drq, 1'b1);
        run_xfers(1, 15);
        chk("R6 burst not extended", drq, 1'b0);
        chk("R6 done at 16", burst_done, 1'b1);

        // held strobe counts once (R11); held write is one write (R2)
        host_write(CTRL, 3);
        chk("R2 held write", drq, 1'b1);
        xfer(1'b0, 1'b0, 3, 1'b0, 1'b0);
        run_xfers(14, 1);
        chk("R11 held strobe counts once", drq, 1'b1);
        run_xfers(1, 15);
        chk("R11 drop at 16", drq, 1'b0);

        // reset in mid-burst (R1) then a fresh burst (R9)
        host_write(CTRL, 1);
        run_xfers(2, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset ends burst", drq, 1'b0);
        chk("R1 reset no done", burst_done, 1'b0);
        run_xfers(1, 0);
        chk("R1 strobe after reset", drq, 1'b0);
        host_write(CTRL, 1);
        run_xfers(15, 0);
        chk("R9 fresh count after 15", drq, 1'b1);
        run_xfers(1, 15);
        chk("R9 fresh count drop", drq, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule